// File: doc/BRIEF.md
# Delayed Handshake Signal Channel

This block models one direction of a point-to-point link. A sender drops line signals of three kinds onto it: request, acknowledge and idle. Each signal comes out at the far end after a programmable number of clock cycles. The channel holds up to two different signals at once. The older one sits at the head, and each entry keeps its own age, counted from the cycle in which it was sent.

The sending side has one strobe per signal kind. The receiving side sees a one-cycle delivery pulse on the output that matches the kind. A repeat of the most recently queued kind merges silently into that entry. A send the channel cannot hold is dropped and sets a sticky error flag. The delay value is taken in only while the channel is empty, so every signal in a burst shares the same bound.

Top module: `sigline_delay`

## Requirements
- R1: After reset no delivery strobe is high and `err` is low.
- R2: A single strobe sent in cycle c to an empty channel, with `dly_in` = D in that cycle, is delivered as a one-cycle pulse in cycle c+1+D (D = 0 gives the next cycle).
- R3: The delivery output matches the queued kind: `send_req`→`rcv_req`, `send_ack`→`rcv_ack`, `send_idle`→`rcv_idle`, where the delivery vector is {idle, ack, req}.
- R4: A send of the same kind as the newest queued signal is absorbed. It adds no delivery, does not restart that entry's age, and does not set `err`.
- R5: With two distinct signals queued, the head is delivered D+1 cycles after its own send. The newer one keeps its own age and is delivered D+1 cycles after its own send.
- R6: `dly_in` is sampled only in cycles where the channel is empty. Changing it while signals are queued does not move their delivery.
- R7: With two signals queued and no delivery in that cycle, a send of a kind other than the newest is dropped and `err` goes high the next cycle. The queued signals are still delivered on time.
- R8: A send in the same cycle as a delivery is judged after the head leaves. It is accepted when it fits and raises no error.
- R9: More than one send strobe in a cycle is dropped and sets `err` the next cycle.
- R10: `err` stays high until reset, and at most one delivery strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_req | input | 1 | Send a request signal this cycle |
| send_ack | input | 1 | Send an acknowledge signal this cycle |
| send_idle | input | 1 | Send an idle signal this cycle |
| dly_in | input | DLY_W (12) | Delivery delay in cycles, sampled while empty |
| rcv_req | output | 1 | Request delivered this cycle |
| rcv_ack | output | 1 | Acknowledge delivered this cycle |
| rcv_idle | output | 1 | Idle delivered this cycle |
| err | output | 1 | Sticky flag for a dropped (illegal) send |

## Verification
The channel is driven with several patterns, and each one separates a different fault.

- **Isolated signal, zero and non-zero delay.** This pins the c+1+D delivery cycle and catches off-by-one errors in the age compare.
- **Repeat followed by a second kind.** This shows whether a duplicate is merged or queued, and whether the newer entry keeps its age when it moves to the head.
- **Send landing in the same cycle as a delivery.** This tells a pop-then-push order apart from a push-then-pop order, which would wrongly flag an overflow.
- **Third kind into a full pair, and simultaneous strobes.** These separate dropping a send from corrupting the queue.
- **Long delay changed mid-flight.** This confirms the delay is latched only while the channel is empty.

// File: rtl/sigline_pkg.sv
package sigline_pkg;

   // Line signal kinds carried by the channel; SK_NONE marks an empty slot.
   typedef enum logic [1:0] {
      SK_NONE = 2'd0,
      SK_REQ  = 2'd1,
      SK_ACK  = 2'd2,
      SK_IDLE = 2'd3
   } sig_kind_t;

   localparam int NUM_KINDS = 3;

endpackage

// File: rtl/sigline_enc.sv
// Turns the per-kind send strobes into a kind code and flags multiple strobes.
module sigline_enc
   import sigline_pkg::*;
(
   input  logic      req,
   input  logic      ack,
   input  logic      idle,
   output sig_kind_t kind,
   output logic      any,
   output logic      multi
);

   always_comb begin
      kind = SK_NONE;
      if (req)       kind = SK_REQ;
      else if (ack)  kind = SK_ACK;
      else if (idle) kind = SK_IDLE;
   end

   assign any   = req | ack | idle;
   assign multi = (req & ack) | (req & idle) | (ack & idle);

endmodule

// File: rtl/sigline_slot.sv
// One queue entry: a signal kind plus its age since it was sent.
module sigline_slot
   import sigline_pkg::*;
#(
   parameter int AGE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_new,
   input  logic             load_fwd,
   input  logic             advance,
   input  sig_kind_t        kind_new,
   input  sig_kind_t        kind_fwd,
   input  logic [AGE_W-1:0] age_fwd,
   output sig_kind_t        kind_q,
   output logic [AGE_W-1:0] age_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= SK_NONE;
         age_q  <= '0;
      end else if (load_new) begin
         kind_q <= kind_new;
         age_q  <= '0;
      end else if (load_fwd) begin
         // entry moving forward keeps its own age, plus the cycle just elapsed
         kind_q <= kind_fwd;
         age_q  <= age_fwd + AGE_W'(1);
      end else if (advance) begin
         age_q  <= age_q + AGE_W'(1);
      end
   end

endmodule

// File: rtl/sigline_dec.sv
// Expands the head kind into one delivery strobe per kind, vector {idle, ack, req}.
module sigline_dec
   import sigline_pkg::*;
(
   input  logic                 fire,
   input  sig_kind_t            kind,
   output logic [NUM_KINDS-1:0] strobe
);

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      assign strobe[k] = fire && (kind == sig_kind_t'(k + 1));
   end

endmodule

// File: rtl/sigline_delay.sv
// Two-entry delayed signal channel with per-entry age and a bounded delivery time.
module sigline_delay
   import sigline_pkg::*;
#(
   parameter int DLY_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             send_req,
   input  logic             send_ack,
   input  logic             send_idle,
   input  logic [DLY_W-1:0] dly_in,
   output logic             rcv_req,
   output logic             rcv_ack,
   output logic             rcv_idle,
   output logic             err
);

   localparam int SLOTS = 2;
   localparam int CNT_W = $clog2(SLOTS + 1);

   if (DLY_W < 1 || DLY_W > 24) begin : g_bad_width
      $error("sigline_delay: DLY_W must lie in 1..24");
   end

   sig_kind_t            snd_kind;
   logic                 snd_any;
   logic                 snd_multi;

   logic [CNT_W-1:0]     q_cnt;
   logic [CNT_W-1:0]     cnt_pop;
   logic [CNT_W-1:0]     cnt_n;
   logic [DLY_W-1:0]     dly_q;

   sig_kind_t            kind_s [SLOTS];
   logic [DLY_W-1:0]     age_s  [SLOTS];
   logic [SLOTS-1:0]     ld_new;
   logic [SLOTS-1:0]     ld_fwd;
   logic [SLOTS-1:0]     adv;

   logic                 fire;
   logic                 push;
   logic                 ovf;
   sig_kind_t            newest;
   logic [NUM_KINDS-1:0] rcv_vec;

   sigline_enc u_enc (
      .req   (send_req),
      .ack   (send_ack),
      .idle  (send_idle),
      .kind  (snd_kind),
      .any   (snd_any),
      .multi (snd_multi)
   );

   // the head leaves exactly when its age reaches the latched delay
   assign fire = (q_cnt != '0) && (age_s[0] == dly_q);

   always_comb begin
      cnt_pop = q_cnt - CNT_W'(fire);
      newest  = (q_cnt == CNT_W'(2)) ? kind_s[1] : kind_s[0];
      ld_new  = '0;
      ld_fwd  = '0;
      push    = 1'b0;
      ovf     = 1'b0;
      if (fire && q_cnt == CNT_W'(2)) ld_fwd[0] = 1'b1;
      // a send is judged against the queue after this cycle's delivery
      if (snd_any && !snd_multi) begin
         if (cnt_pop == '0) begin
            push      = 1'b1;
            ld_new[0] = 1'b1;
         end else if (snd_kind == newest) begin
            push      = 1'b0;   // repeat merges into the newest entry
         end else if (cnt_pop == CNT_W'(1)) begin
            push      = 1'b1;
            ld_new[1] = 1'b1;
         end else begin
            ovf       = 1'b1;
         end
      end
      cnt_n  = cnt_pop + CNT_W'(push);
      adv[0] = (q_cnt != '0);
      adv[1] = (q_cnt == CNT_W'(2));
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      sig_kind_t        fwd_kind;
      logic [DLY_W-1:0] fwd_age;
      if (i < SLOTS - 1) begin : g_mid
         assign fwd_kind = kind_s[i+1];
         assign fwd_age  = age_s[i+1];
      end else begin : g_tail
         assign fwd_kind = SK_NONE;
         assign fwd_age  = '0;
      end
      sigline_slot #(.AGE_W(DLY_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_new (ld_new[i]),
         .load_fwd (ld_fwd[i]),
         .advance  (adv[i]),
         .kind_new (snd_kind),
         .kind_fwd (fwd_kind),
         .age_fwd  (fwd_age),
         .kind_q   (kind_s[i]),
         .age_q    (age_s[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_cnt <= '0;
         dly_q <= '0;
         err   <= 1'b0;
      end else begin
         q_cnt <= cnt_n;
         if (q_cnt == '0)      dly_q <= dly_in;
         if (snd_multi || ovf) err   <= 1'b1;
      end
   end

   sigline_dec u_dec (
      .fire   (fire),
      .kind   (kind_s[0]),
      .strobe (rcv_vec)
   );

   assign {rcv_idle, rcv_ack, rcv_req} = rcv_vec;

endmodule

// File: rtl/sigline_chk.sv
module sigline_chk
   import sigline_pkg::*;
#(
   parameter int DLY_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             send_req,
   input logic             send_ack,
   input logic             send_idle,
   input logic [DLY_W-1:0] dly_in,
   input logic             rcv_req,
   input logic             rcv_ack,
   input logic             rcv_idle,
   input logic             err,
   input logic [1:0]       q_cnt,
   input sig_kind_t        tail_kind
);

   logic any_rcv;
   logic one_send;
   assign any_rcv  = rcv_req | rcv_ack | rcv_idle;
   assign one_send = ($countones({send_req, send_ack, send_idle}) == 1);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!err && !any_rcv));

   assert_zero_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt == 2'd0 && send_req && !send_ack && !send_idle && dly_in == '0) |=> rcv_req);

   assert_no_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt == 2'd0 && one_send && dly_in != '0) |=> !any_rcv);

   assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt == 2'd2 && !any_rcv && send_req && !send_ack && !send_idle
       && tail_kind != SK_REQ) |=> err);

   assert_multi_send_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({send_req, send_ack, send_idle}) > 1) |=> err);

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_one_delivery_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rcv_idle, rcv_ack, rcv_req}));

   assert_empty_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt == 2'd0) |-> !any_rcv);

endmodule

bind sigline_delay sigline_chk #(.DLY_W(DLY_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .send_req  (send_req),
   .send_ack  (send_ack),
   .send_idle (send_idle),
   .dly_in    (dly_in),
   .rcv_req   (rcv_req),
   .rcv_ack   (rcv_ack),
   .rcv_idle  (rcv_idle),
   .err       (err),
   .q_cnt     (q_cnt),
   .tail_kind (kind_s[1])
);

// File: tb/sim_sigline_delay.sv
module sim_sigline_delay;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        send_req = 1'b0;
   logic        send_ack = 1'b0;
   logic        send_idle = 1'b0;
   logic [11:0] dly_in = '0;
   logic        rcv_req, rcv_ack, rcv_idle, err;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;   // 125 MHz

   sigline_delay #(.DLY_W(12)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .send_req  (send_req),
      .send_ack  (send_ack),
      .send_idle (send_idle),
      .dly_in    (dly_in),
      .rcv_req   (rcv_req),
      .rcv_ack   (rcv_ack),
      .rcv_idle  (rcv_idle),
      .err       (err)
   );

   // vector = {send{idle,ack,req}, delay[3:0], expected rcv{idle,ack,req}, expected err}
   localparam int NV = 20;
   localparam logic [10:0] VEC [NV] = '{
      {3'b001, 4'd2, 3'b000, 1'b0},  // 0  req from empty, due 3
      {3'b001, 4'd2, 3'b000, 1'b0},  // 1  repeat absorbed
      {3'b010, 4'd7, 3'b000, 1'b0},  // 2  ack queued, due 5, delay ignored
      {3'b000, 4'd7, 3'b001, 1'b0},  // 3  req out
      {3'b000, 4'd7, 3'b000, 1'b0},  // 4
      {3'b000, 4'd0, 3'b010, 1'b0},  // 5  ack out, own age kept
      {3'b100, 4'd0, 3'b000, 1'b0},  // 6  idle, zero delay
      {3'b000, 4'd0, 3'b100, 1'b0},  // 7  idle next cycle
      {3'b001, 4'd1, 3'b000, 1'b0},  // 8  req, due 10
      {3'b010, 4'd5, 3'b000, 1'b0},  // 9  ack, due 11
      {3'b100, 4'd5, 3'b001, 1'b0},  // 10 idle sent during delivery, due 12
      {3'b000, 4'd5, 3'b010, 1'b0},  // 11
      {3'b000, 4'd5, 3'b100, 1'b0},  // 12
      {3'b001, 4'd3, 3'b000, 1'b0},  // 13 req, due 17
      {3'b010, 4'd1, 3'b000, 1'b0},  // 14 ack, due 18
      {3'b100, 4'd1, 3'b000, 1'b0},  // 15 third kind: overflow
      {3'b000, 4'd1, 3'b000, 1'b1},  // 16 err raised
      {3'b000, 4'd1, 3'b001, 1'b1},  // 17 queue intact
      {3'b000, 4'd1, 3'b010, 1'b1},  // 18
      {3'b000, 4'd1, 3'b000, 1'b1}   // 19 nothing from dropped send
   };

   function automatic string row_tag(int i);
      if (i <= 7)       return "R2 R3 R4 R5 R6";
      else if (i <= 12) return "R3 R8";
      else              return "R7 R10";
   endfunction

   task automatic tick(input logic [2:0] s, input logic [11:0] d,
                       input logic [2:0] exp_rcv, input logic exp_err, input string tag);
      @(negedge clk);
      {send_idle, send_ack, send_req} = s;
      dly_in = d;
      #1;
      n_tests++;
      if ({rcv_idle, rcv_ack, rcv_req} !== exp_rcv || err !== exp_err) begin
         n_fail++;
         $display("FAIL %s: rcv=%b err=%b expected rcv=%b err=%b",
                  tag, {rcv_idle, rcv_ack, rcv_req}, err, exp_rcv, exp_err);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      {send_idle, send_ack, send_req} = 3'b000;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 20000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      tick(3'b000, 12'd0, 3'b000, 1'b0, "R1 reset state");

      for (int i = 0; i < NV; i++) begin
         tick(VEC[i][10:8], {8'd0, VEC[i][7:4]}, VEC[i][3:1], VEC[i][0], row_tag(i));
      end

      // R10: reset clears the sticky flag
      do_reset();
      tick(3'b000, 12'd0, 3'b000, 1'b0, "R10 err cleared by reset");

      // R9: two strobes at once are dropped and flagged
      tick(3'b011, 12'd0, 3'b000, 1'b0, "R9 multi send");
      tick(3'b000, 12'd0, 3'b000, 1'b1, "R9 err after multi send, nothing delivered");
      tick(3'b000, 12'd0, 3'b000, 1'b1, "R9 still nothing delivered");

      // R2/R6: long delay, changed while in flight
      do_reset();
      tick(3'b001, 12'd20, 3'b000, 1'b0, "R2 long delay send");
      for (int i = 1; i <= 22; i++) begin
         tick(3'b000, (i < 10) ? 12'd3 : 12'd40, (i == 21) ? 3'b001 : 3'b000, 1'b0,
              "R2 R6 long delay timing");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule